// File: doc/BRIEF.md
# Microprogram Sequencer With Multiway Branch

This block is the control sequencer of a microprogrammed processor. It owns a microprogram counter, a control store of microinstruction words, and the microinstruction register whose fields steer the datapath. Each microinstruction carries the address of its successor. There is no implicit increment. A three-bit jump-control field changes that successor in the same cycle. Two of its bits let the registered negative and zero flags set the top address bit, which gives a two-way conditional branch. The third bit merges the opcode byte from the fetch buffer into the low address bits. This produces a multiway dispatch to the entry point of the opcode.

The control store has a plain write port, used by the environment to load the microprogram. On every rising edge the sequencer forms the next address. It then loads that address into the counter and loads the word stored there into the microinstruction register. The register's memory-control field is valid from that edge, so a memory read is launched on the same edge. The datapath itself lies outside this block. It only supplies the flag inputs and the opcode byte.

Top module: `microseq`

## Requirements
- R1: While rst_ni is low, mpc_o is 0 and mir_o is all zeros, which is a no-operation word whose successor is address 0 with no jump control.
- R2: When the jump-control field (mir_o[26:24]) is 000, the next mpc_o equals the successor field (mir_o[35:27]) exactly, with no increment, including address 0x1FF.
- R3: With jump-control bit 1 set, bit 8 of the next address is the successor's bit 8 ORed with the registered negative flag.
- R4: With jump-control bit 0 set, bit 8 of the next address is the successor's bit 8 ORed with the registered zero flag.
- R5: With jump-control bit 2 set, bits 7:0 of the next address are the successor's bits 7:0 ORed with mbr_i, and bit 8 is not altered by mbr_i.
- R6: The flags used for a branch are n_i and z_i as sampled at the rising edge that began the current microinstruction; their values during the current cycle have no effect on its branch.
- R7: The field outputs decode the microinstruction register: alu_ctrl_o = mir_o[23:16], c_wr_o = mir_o[15:7], mem_op_o = mir_o[6:4], b_sel_o = mir_o[3:0].
- R8: With both flag bits of the jump control set, bit 8 of the next address is set if either registered flag is 1. When no enabled flag is 1, bit 8 is kept from the successor field.
- R9: At each rising edge out of reset, mpc_o takes the next address and mir_o takes the control-store word at that address. A store write is committed at its edge, so a fetch of the same address on that edge returns the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_we_i | input | 1 | Control-store write enable |
| cs_waddr_i | input | 9 | Control-store write address |
| cs_wdata_i | input | 36 | Control-store write word |
| mbr_i | input | 8 | Opcode byte from the fetch buffer |
| n_i | input | 1 | Negative flag from the ALU |
| z_i | input | 1 | Zero flag from the ALU |
| mpc_o | output | 9 | Microprogram counter (address of mir_o) |
| mir_o | output | 36 | Microinstruction register |
| alu_ctrl_o | output | 8 | ALU and shifter control field |
| c_wr_o | output | 9 | Register write enables from the C bus |
| mem_op_o | output | 3 | Memory operation field |
| b_sel_o | output | 4 | Encoded B-bus source select |

## Verification
A linked microprogram is walked one microinstruction per cycle. The rows exercise plain successors, each flag test with its flag set and clear, both flag tests together, and opcode dispatch with disjoint and overlapping bits. Flags and the opcode byte are held at 1 under a zero jump field to show they are ignored there. The live flag value during a cycle is chosen to differ from the registered one, which separates the registered flag from a combinational one. Directed tests add a mid-run reset and a rewrite of a store entry on the same edge that fetches it, then fetch it again to see the new word.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ADDR_W = 9;
  localparam int JAM_W  = 3;
  localparam int ALU_W  = 8;
  localparam int CWR_W  = 9;
  localparam int MEM_W  = 3;
  localparam int BSEL_W = 4;
  localparam int OPC_W  = 8;
  localparam int WORD_W = ADDR_W + JAM_W + ALU_W + CWR_W + MEM_W + BSEL_W;
  localparam int DEPTH  = 1 << ADDR_W;

  // jump-control bit positions
  localparam int JAM_Z  = 0;
  localparam int JAM_N  = 1;
  localparam int JAM_PC = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] succ;
    logic [JAM_W-1:0]  jam;
    logic [ALU_W-1:0]  alu;
    logic [CWR_W-1:0]  cwr;
    logic [MEM_W-1:0]  mem;
    logic [BSEL_W-1:0] bsel;
  } uinst_t;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW = 9,
  parameter int DW = 36,
  localparam int NW = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [NW];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read is combinational; the MIR register samples it
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/useq_flags.sv
module useq_flags #(
  parameter int NF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] flag_i,
  output logic [NF-1:0] flag_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= flag_i[g];
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] succ_i,
  input  logic [JAM_W-1:0]  jam_i,
  input  logic              n_q_i,
  input  logic              z_q_i,
  input  logic [OPC_W-1:0]  opc_i,
  output logic [ADDR_W-1:0] nxt_o
);
  logic             hi_set;
  logic [OPC_W-1:0] opc_or;

  assign hi_set = (jam_i[JAM_N] & n_q_i) | (jam_i[JAM_Z] & z_q_i);
  assign opc_or = jam_i[JAM_PC] ? opc_i : '0;

  always_comb begin
    nxt_o = succ_i;
    nxt_o[ADDR_W-1]  = succ_i[ADDR_W-1] | hi_set;
    nxt_o[OPC_W-1:0] = succ_i[OPC_W-1:0] | opc_or;
  end
endmodule

// File: rtl/microseq.sv
module microseq
  import useq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_we_i,
  input  logic [ADDR_W-1:0] cs_waddr_i,
  input  logic [WORD_W-1:0] cs_wdata_i,
  input  logic [OPC_W-1:0]  mbr_i,
  input  logic              n_i,
  input  logic              z_i,
  output logic [ADDR_W-1:0] mpc_o,
  output logic [WORD_W-1:0] mir_o,
  output logic [ALU_W-1:0]  alu_ctrl_o,
  output logic [CWR_W-1:0]  c_wr_o,
  output logic [MEM_W-1:0]  mem_op_o,
  output logic [BSEL_W-1:0] b_sel_o
);
  logic [ADDR_W-1:0] mpc_q, nxt;
  uinst_t            mir_q;
  logic [WORD_W-1:0] cs_rdata;
  logic [1:0]        flag_q;

  useq_flags #(.NF(2)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i ({n_i, z_i}),
    .flag_o (flag_q)
  );

  useq_next u_next (
    .succ_i (mir_q.succ),
    .jam_i  (mir_q.jam),
    .n_q_i  (flag_q[1]),
    .z_q_i  (flag_q[0]),
    .opc_i  (mbr_i),
    .nxt_o  (nxt)
  );

  useq_store #(.AW(ADDR_W), .DW(WORD_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (cs_we_i),
    .waddr_i (cs_waddr_i),
    .wdata_i (cs_wdata_i),
    .raddr_i (nxt),
    .rdata_o (cs_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mpc_q <= '0;
      mir_q <= '0;
    end else begin
      mpc_q <= nxt;
      mir_q <= uinst_t'(cs_rdata);
    end
  end

  assign mpc_o      = mpc_q;
  assign mir_o      = mir_q;
  assign alu_ctrl_o = mir_q.alu;
  assign c_wr_o     = mir_q.cwr;
  assign mem_op_o   = mir_q.mem;
  assign b_sel_o    = mir_q.bsel;
endmodule

module microseq_chk
  import useq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OPC_W-1:0]  mbr_i,
  input logic              n_i,
  input logic              z_i,
  input logic [ADDR_W-1:0] mpc_o,
  input logic [WORD_W-1:0] mir_o
);
  logic   past_ok;
  uinst_t mi;
  assign mi = uinst_t'(mir_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R1
  rst_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (mpc_o == '0) && (mir_o == '0));

  // R2
  plain_succ_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && (mi.jam == '0) |=> mpc_o == $past(mi.succ));

  // R3
  neg_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && mi.jam[JAM_N] && $past(n_i) |=> mpc_o[ADDR_W-1]);

  // R4
  zero_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && mi.jam[JAM_Z] && $past(z_i) |=> mpc_o[ADDR_W-1]);

  // R5
  dispatch_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |=> mpc_o[OPC_W-1:0] == ($past(mi.succ[OPC_W-1:0]) |
      ($past(mi.jam[JAM_PC]) ? $past(mbr_i) : {OPC_W{1'b0}})));

  // R8
  high_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !(mi.jam[JAM_N] && $past(n_i)) && !(mi.jam[JAM_Z] && $past(z_i))
      |=> mpc_o[ADDR_W-1] == $past(mi.succ[ADDR_W-1]));
endmodule

bind microseq microseq_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mbr_i  (mbr_i),
  .n_i    (n_i),
  .z_i    (z_i),
  .mpc_o  (mpc_o),
  .mir_o  (mir_o)
);

// File: tb/microseq_tb_top.sv
`timescale 1ns/1ps
module microseq_tb_top;
  import useq_pkg::*;

  typedef struct packed {
    logic [8:0] succ;
    logic [2:0] jam;
    logic [7:0] mbr;
    logic       n;
    logic       z;
    logic [8:0] exp;
  } vec_t;

  localparam int NV = 14;
  // chain: row i lives at the previous row's expected address (row 0 at 0)
  localparam vec_t VEC [NV] = '{
    '{9'h005, 3'b000, 8'hFF, 1'b1, 1'b1, 9'h005},
    '{9'h010, 3'b010, 8'h00, 1'b1, 1'b0, 9'h110},
    '{9'h020, 3'b010, 8'h00, 1'b0, 1'b1, 9'h020},
    '{9'h030, 3'b001, 8'h00, 1'b0, 1'b1, 9'h130},
    '{9'h040, 3'b001, 8'h00, 1'b1, 1'b0, 9'h040},
    '{9'h100, 3'b100, 8'h3C, 1'b1, 1'b1, 9'h13C},
    '{9'h000, 3'b100, 8'h60, 1'b0, 1'b0, 9'h060},
    '{9'h081, 3'b100, 8'h42, 1'b0, 1'b0, 9'h0C3},
    '{9'h050, 3'b011, 8'h00, 1'b1, 1'b0, 9'h150},
    '{9'h070, 3'b011, 8'h00, 1'b0, 1'b1, 9'h170},
    '{9'h0A0, 3'b011, 8'h00, 1'b0, 1'b0, 9'h0A0},
    '{9'h180, 3'b010, 8'h00, 1'b0, 1'b0, 9'h180},
    '{9'h0F0, 3'b111, 8'h0F, 1'b1, 1'b0, 9'h1FF},
    '{9'h1FF, 3'b000, 8'h00, 1'b0, 1'b0, 9'h1FF}
  };
  localparam string TAG [NV] = '{
    "R2", "R6", "R3", "R4", "R6", "R5", "R5",
    "R5", "R8", "R8", "R8", "R3", "R5", "R2"
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cs_we_i = 1'b0;
  logic [ADDR_W-1:0] cs_waddr_i = '0;
  logic [WORD_W-1:0] cs_wdata_i = '0;
  logic [OPC_W-1:0]  mbr_i = '0;
  logic              n_i = 1'b0, z_i = 1'b0;
  logic [ADDR_W-1:0] mpc_o;
  logic [WORD_W-1:0] mir_o;
  logic [ALU_W-1:0]  alu_ctrl_o;
  logic [CWR_W-1:0]  c_wr_o;
  logic [MEM_W-1:0]  mem_op_o;
  logic [BSEL_W-1:0] b_sel_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  microseq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_we_i(cs_we_i), .cs_waddr_i(cs_waddr_i),
    .cs_wdata_i(cs_wdata_i), .mbr_i(mbr_i), .n_i(n_i), .z_i(z_i),
    .mpc_o(mpc_o), .mir_o(mir_o), .alu_ctrl_o(alu_ctrl_o), .c_wr_o(c_wr_o),
    .mem_op_o(mem_op_o), .b_sel_o(b_sel_o)
  );

  function automatic logic [35:0] mk_word(logic [8:0] succ, logic [2:0] jam, logic [8:0] loc);
    return {succ, jam, loc[7:0] ^ 8'h5A, ~loc, loc[2:0], loc[3:0] ^ 4'h9};
  endfunction

  function automatic logic [23:0] fields_of(logic [8:0] loc);
    return {loc[7:0] ^ 8'h5A, ~loc, loc[2:0], loc[3:0] ^ 4'h9};
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cs_write(input logic [8:0] a, input logic [35:0] d);
    cs_we_i = 1'b1; cs_waddr_i = a; cs_wdata_i = d;
    @(negedge clk);
    cs_we_i = 1'b0;
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [8:0] loc;
    @(negedge clk);
    // R9: load the linked program through the write port
    loc = 9'h000;
    for (int i = 0; i < NV; i++) begin
      cs_write(loc, mk_word(VEC[i].succ, VEC[i].jam, loc));
      loc = VEC[i].exp;
    end
    chk("R1", "mpc in reset", 64'(mpc_o), 64'h0);
    chk("R1", "mir in reset", 64'(mir_o), 64'h0);
    chk("R1", "fields in reset", 64'({alu_ctrl_o, c_wr_o, mem_op_o, b_sel_o}), 64'h0);

    n_i = VEC[0].n; z_i = VEC[0].z;
    rst_ni = 1'b1;
    @(negedge clk);
    loc = 9'h000;
    for (int i = 0; i < NV; i++) begin
      chk("R9", "mir word", 64'(mir_o), 64'(mk_word(VEC[i].succ, VEC[i].jam, loc)));
      chk("R7", "field outputs", 64'({alu_ctrl_o, c_wr_o, mem_op_o, b_sel_o}), 64'(fields_of(loc)));
      mbr_i = VEC[i].mbr;
      // live flags belong to the next row; R6 says they must not steer this one
      n_i = (i + 1 < NV) ? VEC[i+1].n : 1'b0;
      z_i = (i + 1 < NV) ? VEC[i+1].z : 1'b0;
      @(negedge clk);
      chk(TAG[i], "next mpc", 64'(mpc_o), 64'(VEC[i].exp));
      loc = VEC[i].exp;
    end
    // R2 self loop at the top address
    chk("R2", "self loop word", 64'(mir_o), 64'(mk_word(9'h1FF, 3'b000, 9'h1FF)));

    // mid-run reset
    rst_ni = 1'b0;
    #1;
    chk("R1", "mpc after async reset", 64'(mpc_o), 64'h0);
    chk("R1", "mir after async reset", 64'(mir_o), 64'h0);
    @(negedge clk);
    n_i = 1'b0; z_i = 1'b0; mbr_i = 8'h00;
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2", "restart at zero", 64'(mpc_o), 64'h0);
    chk("R9", "restart word", 64'(mir_o), 64'(mk_word(VEC[0].succ, VEC[0].jam, 9'h000)));

    // R9: rewrite 0x005 on the edge that fetches it
    cs_write(9'h005, mk_word(9'h0AA, 3'b000, 9'h1E1));
    chk("R9", "same-edge fetch mpc", 64'(mpc_o), 64'h005);
    chk("R9", "same-edge fetch old word", 64'(mir_o), 64'(mk_word(VEC[1].succ, VEC[1].jam, 9'h005)));

    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "new word fetched", 64'(mir_o), 64'(mk_word(9'h0AA, 3'b000, 9'h1E1)));
    chk("R7", "new word fields", 64'({alu_ctrl_o, c_wr_o, mem_op_o, b_sel_o}), 64'(fields_of(9'h1E1)));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule